// File: doc/BRIEF.md
# Synthesizer Fault Flag Monitor

This block produces the single error line of a synthesizer controller. It watches four status sources: the loop's lock detect, a comparator saying the tuning supply is out of range, a comparator saying the internal regulator is out of range, and a pulse from the command decoder that marks a command carrying an invalid frequency or reference value. It folds them into one drive-high enable for the shared error line.

The output never pulls the line low. When `flag_drive_o` is 0 the pad is released and an external pull-down sets the level. This lets several synthesizers share one wire as a wired-OR. After reset the line is driven high. It is released only once lock detect has stayed high through a debounce window and then a programmable confirmation delay. Any fault drives it high again.

The lock and both range inputs pass through debounce filters of `DEB_CYCLES` samples. A command fault is latched until the decoder commits the next valid command.

Top module: `synth_fault_flag`

## Requirements
- R1: While reset is asserted, and after it until the first lock confirmation, `flag_drive_o` is 1.
- R2: With no other fault, once `lock_det_i` rises and stays high, `flag_drive_o` falls exactly DEB_CYCLES + `confirm_cycles_i` clock edges after the first edge that samples it high. With the default DEB_CYCLES = 4 and `confirm_cycles_i` = 10, that is the 14th edge.
- R3: If `lock_det_i` drops for DEB_CYCLES consecutive samples, `flag_drive_o` rises on the following edge, which is edge DEB_CYCLES + 1. The confirmation delay then restarts in full. A low glitch shorter than DEB_CYCLES samples has no effect.
- R4: If `vtune_oor_i` is high for DEB_CYCLES consecutive samples, `flag_drive_o` rises on the DEB_CYCLES-th edge. When the input has been low for DEB_CYCLES samples, the line is released on the DEB_CYCLES-th edge. A pulse shorter than DEB_CYCLES samples has no effect.
- R5: `vreg_oor_i` behaves exactly as in R4.
- R6: A one-cycle `cmd_invalid_i` pulse sets `flag_drive_o` on the next edge. The fault stays latched until a `cmd_commit_i` pulse, and the line is released on the edge that samples the commit, provided no other fault is present.
- R7: When `cmd_invalid_i` and `cmd_commit_i` are sampled on the same edge, the invalid command wins and the fault stays latched.
- R8: A `confirm_cycles_i` value of 0 is treated as 1. The line is then released on edge DEB_CYCLES + 1 after lock rises.
- R9: The line is released only when every fault source is clear. Clearing one of two active faults keeps `flag_drive_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_det_i | input | 1 | Loop lock detect, high when locked |
| vtune_oor_i | input | 1 | Tuning supply out of range |
| vreg_oor_i | input | 1 | Internal regulator out of range |
| cmd_invalid_i | input | 1 | One-cycle pulse: invalid frequency or reference command |
| cmd_commit_i | input | 1 | One-cycle pulse: a valid command was committed |
| confirm_cycles_i | input | CNT_W | Lock confirmation delay in cycles (0 acts as 1) |
| flag_drive_o | output | 1 | Drive-high enable for the shared error line |

## Verification
The bench targets the exact release edge after lock. A design that starts counting the confirmation delay on raw lock detect, rather than on the filtered value, releases early. A design that adds a register to the output releases one edge late. Short low glitches on lock and short range pulses are applied at one sample under the debounce depth; an off-by-one filter would either restart confirmation or raise the line. A same-cycle invalid-and-commit is applied to catch a latch that gives priority to the clear, and a zero confirmation count is applied to catch a counter that wraps and waits about 65 thousand cycles.

// File: rtl/synth_flag_pkg.sv
// Package: shared types of the synthesizer fault flag monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package synth_flag_pkg;

    // Number of analog range comparators watched by the block.
    localparam int NUM_RANGE = 2;

    // Index of each range comparator inside the range vector.
    localparam int RANGE_VTUNE = 0;
    localparam int RANGE_VREG  = 1;

    // One bit per fault source; any set bit drives the line high.
    typedef struct packed {
        logic                 unlocked;
        logic [NUM_RANGE-1:0] range_bad;
        logic                 cmd_bad;
    } fault_vec_t;

endpackage

// File: rtl/flt_debounce.sv
// Module: flt_debounce
// Adopts a new level of raw_i only after DEPTH consecutive samples that all
// differ from the current filtered value. A run that is interrupted resets the
// count. Assumes raw_i is already synchronous to clk and DEPTH >= 1.
module flt_debounce #(
    parameter int   DEPTH = 4,
    parameter logic INIT  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] run_q;

    // Count differing samples and adopt the new level on the DEPTH-th one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_o <= INIT;
        end else if (raw_i != filt_o) begin
            if (run_q == LAST) begin
                filt_o <= raw_i;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // R4: the filtered level only ever moves towards the level last sampled.
    assert_filter_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));

endmodule

// File: rtl/lock_confirm.sv
// Module: lock_confirm
// Declares lock confirmed after the filtered lock input has been high for
// limit_i consecutive cycles; a limit of 0 counts as 1. Loss of lock clears
// the confirmation and restarts the count. Assumes lock_ok_i is debounced.
module lock_confirm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_ok_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             confirmed_o
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] last_idx;

    // Last count index before confirmation, with 0 folded onto 1.
    always_comb begin
        last_idx = (limit_i == '0) ? '0 : (limit_i - 1'b1);
    end

    // Run the confirmation counter while locked; clear everything on loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            confirmed_o <= 1'b0;
        end else if (!lock_ok_i) begin
            run_q       <= '0;
            confirmed_o <= 1'b0;
        end else if (!confirmed_o) begin
            if (run_q >= last_idx) begin
                confirmed_o <= 1'b1;
                run_q       <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R2: confirmation can only appear while the filtered lock was present.
    assert_confirm_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(confirmed_o) |-> $past(lock_ok_i));

    // R3: losing filtered lock withdraws confirmation on the next edge.
    assert_loss_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok_i |=> !confirmed_o);

endmodule

// File: rtl/cmd_fault_latch.sv
// Module: cmd_fault_latch
// Holds the invalid-command fault from an invalid pulse until a commit pulse.
// The invalid pulse wins when both arrive together. Assumes both inputs are
// single-cycle pulses from the command decoder.
module cmd_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic invalid_i,
    input  logic commit_i,
    output logic fault_o
);
    // Set on invalid, clear on commit, invalid has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o <= 1'b0;
        end else if (invalid_i) begin
            fault_o <= 1'b1;
        end else if (commit_i) begin
            fault_o <= 1'b0;
        end
    end

    // R6: an invalid command is always latched on the next edge (R7 priority).
    assert_invalid_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_i |=> fault_o);

    // R6: the fault only clears in response to a commit.
    assert_clear_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> $past(commit_i));

endmodule

// File: rtl/synth_fault_flag.sv
// Module: synth_fault_flag (top)
// Folds lock loss, range comparator faults and invalid commands into one
// drive-high enable for a shared, externally pulled-down error line. Assumes
// all inputs are synchronous to clk and the command pulses last one cycle.
module synth_fault_flag
    import synth_flag_pkg::*;
#(
    parameter int DEB_CYCLES = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_det_i,
    input  logic             vtune_oor_i,
    input  logic             vreg_oor_i,
    input  logic             cmd_invalid_i,
    input  logic             cmd_commit_i,
    input  logic [CNT_W-1:0] confirm_cycles_i,
    output logic             flag_drive_o
);
    logic [NUM_RANGE-1:0] range_raw;
    logic [NUM_RANGE-1:0] range_filt;
    logic                 lock_filt;
    logic                 lock_conf;
    logic                 cmd_fault;
    fault_vec_t           faults;

    // Gather the raw comparator inputs into one indexed vector.
    always_comb begin
        range_raw              = '0;
        range_raw[RANGE_VTUNE] = vtune_oor_i;
        range_raw[RANGE_VREG]  = vreg_oor_i;
    end

    // One debounce filter per range comparator.
    for (genvar g = 0; g < NUM_RANGE; g++) begin : g_range
        flt_debounce #(.DEPTH(DEB_CYCLES), .INIT(1'b0)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (range_raw[g]),
            .filt_o (range_filt[g])
        );
    end

    flt_debounce #(.DEPTH(DEB_CYCLES), .INIT(1'b0)) u_lock_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (lock_det_i),
        .filt_o (lock_filt)
    );

    lock_confirm #(.CNT_W(CNT_W)) u_confirm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_ok_i   (lock_filt),
        .limit_i     (confirm_cycles_i),
        .confirmed_o (lock_conf)
    );

    cmd_fault_latch u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .invalid_i (cmd_invalid_i),
        .commit_i  (cmd_commit_i),
        .fault_o   (cmd_fault)
    );

    // Assemble the fault vector from the registered sources.
    always_comb begin
        faults.unlocked  = !lock_conf;
        faults.range_bad = range_filt;
        faults.cmd_bad   = cmd_fault;
    end

    // Wired-OR contribution: drive high whenever any fault is present.
    assign flag_drive_o = |faults;

    // R1: the first cycle out of reset always drives the line.
    assert_reset_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> flag_drive_o);

    // R9: a latched command fault keeps the line driven.
    assert_cmd_fault_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fault |-> flag_drive_o);

endmodule

// File: tb/synth_fault_flag_tb_top.sv
// Bench: scoreboard of timed expectations. Driver code pushes the expected
// flag level due after a number of clock edges; a monitor compares on the
// falling edge when each item falls due.
module synth_fault_flag_tb_top;

    localparam int DEB = 4;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lock_det, vtune, vreg, cmd_inv, cmd_commit;
    logic [CW-1:0] confirm;
    logic          flag;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int    due;
        bit    val;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    synth_fault_flag #(.DEB_CYCLES(DEB), .CNT_W(CW)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .lock_det_i       (lock_det),
        .vtune_oor_i      (vtune),
        .vreg_oor_i       (vreg),
        .cmd_invalid_i    (cmd_inv),
        .cmd_commit_i     (cmd_commit),
        .confirm_cycles_i (confirm),
        .flag_drive_o     (flag)
    );

    // Queue an expected flag level k edges from now.
    task automatic expect_flag(input int k, input bit v, input string r);
        exp_t e;
        e.due = cyc + k;
        e.val = v;
        e.req = r;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every item that falls due at this falling edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                n_checks++;
                if (flag !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s: cycle %0d flag=%0b expected %0b",
                             sb[i].req, cyc, flag, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    // Driver: stimulus and expectations per requirement.
    initial begin
        rst_n = 1'b0; lock_det = 1'b0; vtune = 1'b0; vreg = 1'b0;
        cmd_inv = 1'b0; cmd_commit = 1'b0; confirm = CW'(10);
        tick(3);
        expect_flag(1, 1'b1, "R1");                 // held during reset
        tick(2);
        rst_n = 1'b1;
        expect_flag(1, 1'b1, "R1");
        expect_flag(8, 1'b1, "R1");                 // no lock yet
        tick(10);

        // R2: release on edge DEB + 10
        lock_det = 1'b1;
        expect_flag(DEB + 9, 1'b1, "R2");
        expect_flag(DEB + 10, 1'b0, "R2");
        tick(20);

        // R3: short low glitch on lock is ignored
        lock_det = 1'b0;
        expect_flag(8, 1'b0, "R3");
        tick(DEB - 1);
        lock_det = 1'b1;
        tick(10);

        // R3: real loss raises the line, then full re-confirmation
        lock_det = 1'b0;
        expect_flag(DEB, 1'b0, "R3");
        expect_flag(DEB + 1, 1'b1, "R3");
        tick(8);
        lock_det = 1'b1;
        expect_flag(DEB + 9, 1'b1, "R3");
        expect_flag(DEB + 10, 1'b0, "R3");
        tick(20);

        // R4: tuning supply fault, release, and a short ignored pulse
        vtune = 1'b1;
        expect_flag(DEB - 1, 1'b0, "R4");
        expect_flag(DEB, 1'b1, "R4");
        tick(8);
        vtune = 1'b0;
        expect_flag(DEB - 1, 1'b1, "R4");
        expect_flag(DEB, 1'b0, "R4");
        tick(8);
        vtune = 1'b1;
        expect_flag(6, 1'b0, "R4");
        tick(DEB - 1);
        vtune = 1'b0;
        tick(8);

        // R5: regulator fault follows the same rules
        vreg = 1'b1;
        expect_flag(DEB - 1, 1'b0, "R5");
        expect_flag(DEB, 1'b1, "R5");
        tick(8);
        vreg = 1'b0;
        expect_flag(DEB - 1, 1'b1, "R5");
        expect_flag(DEB, 1'b0, "R5");
        tick(8);
        vreg = 1'b1;
        expect_flag(6, 1'b0, "R5");
        tick(DEB - 1);
        vreg = 1'b0;
        tick(8);

        // R6: invalid command latches until commit
        cmd_inv = 1'b1;
        expect_flag(1, 1'b1, "R6");
        tick(1);
        cmd_inv = 1'b0;
        expect_flag(5, 1'b1, "R6");
        tick(6);
        cmd_commit = 1'b1;
        expect_flag(1, 1'b0, "R6");
        tick(1);
        cmd_commit = 1'b0;
        tick(4);

        // R7: invalid beats a simultaneous commit
        cmd_inv = 1'b1;
        cmd_commit = 1'b1;
        expect_flag(1, 1'b1, "R7");
        expect_flag(4, 1'b1, "R7");
        tick(1);
        cmd_inv = 1'b0;
        cmd_commit = 1'b0;
        tick(5);
        cmd_commit = 1'b1;
        expect_flag(1, 1'b0, "R7");
        tick(1);
        cmd_commit = 1'b0;
        tick(3);

        // R8: zero confirmation count acts as one
        lock_det = 1'b0;
        tick(10);
        confirm = '0;
        lock_det = 1'b1;
        expect_flag(DEB, 1'b1, "R8");
        expect_flag(DEB + 1, 1'b0, "R8");
        tick(10);

        // R9: two faults; clearing one keeps the line driven
        vtune = 1'b1;
        cmd_inv = 1'b1;
        expect_flag(1, 1'b1, "R9");
        tick(1);
        cmd_inv = 1'b0;
        tick(6);
        cmd_commit = 1'b1;
        expect_flag(1, 1'b1, "R9");
        expect_flag(3, 1'b1, "R9");
        tick(1);
        cmd_commit = 1'b0;
        tick(4);
        vtune = 1'b0;
        expect_flag(DEB - 1, 1'b1, "R9");
        expect_flag(DEB, 1'b0, "R9");
        tick(8);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycle %0d reached, expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule